// File: doc/BRIEF.md
# Interleaved Sprite and Sample DMA Sequencer

This block decides what a CPU-side DMA unit puts on the shared bus in every cycle. Two engines use that bus. The sprite engine starts when the CPU writes a page number to a trigger address. It then copies a block of bytes from that page to a fixed data port, one read and one write per byte. The sample engine fetches one byte at a time when the audio side asks for it. All cycles follow an alternating get/put grid. DMA reads use only get cycles and DMA writes use only put cycles.

Before either engine touches the bus, the CPU has to be stopped. The stop is allowed only on a CPU read cycle. While the CPU is stopped, every cycle that no engine uses repeats the CPU's pending read address as a dummy read. The sample engine needs a halt step, a dummy step and, when needed, an alignment step before its fetch. If it runs while a sprite copy is under way, these steps overlap the sprite cycles. Its fetch then takes a get slot from the sprite engine, and the sprite engine spends the following put cycle realigning.

Top module: `sprdma_seq`

## Requirements
- R1: A CPU write cycle (`cpu_rd`=0) to address 0x4014 arms the sprite engine while it is idle. `cpu_wdata` becomes the source page, so byte n is read from address {page, n}.
- R2: `cpu_halt` rises only in a cycle where `cpu_rd`=1. A pending request that meets a CPU write waits for the next read cycle. In the first halted cycle, `bus_addr` repeats `cpu_addr` with `bus_rd`=1.
- R3: If the cycle after the sprite halt cycle is a put (`get_cyc`=0), that cycle is an alignment cycle that repeats `cpu_addr`. The first sprite read follows on the next get.
- R4: Sprite byte n is read from {page, n} on a get cycle. On the next put cycle the same byte is written to address 0x2004 with `bus_rd`=0 and `spr_wr`=1.
- R5: After BYTES read/write pairs the copy ends. `cpu_halt` falls in the cycle after the last write, unless a sample fetch is still pending, and the bus follows the CPU again.
- R6: A sample fetch goes through a halt cycle, then a dummy cycle, then alignment cycles until a get cycle. On that get cycle it reads `smp_addr`.
- R7: One cycle after each sample fetch, `smp_done` pulses for one cycle and `smp_data` holds the fetched byte.
- R8: When a sample fetch and a sprite read want the same get slot, the sample fetch wins. The sprite engine repeats `cpu_addr` on the next put cycle and reads on the following get.
- R9: A sample request made in the cycle of a fetch starts a fresh halt, dummy and alignment sequence. Inside a sprite copy these steps overlap sprite cycles, and the new fetch takes a later get slot.
- R10: While `rst_n` is low, `cpu_halt` and `smp_done` are 0 and `bus_addr`/`bus_rd` follow the CPU. A reset in the middle of a copy abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| get_cyc | input | 1 | 1 on get cycles, 0 on put cycles |
| cpu_rd | input | 1 | CPU access direction, 1 = read |
| cpu_addr | input | AW | Address the CPU presents |
| cpu_wdata | input | 8 | CPU write data (page number on trigger) |
| smp_req | input | 1 | Sample byte request |
| smp_addr | input | AW | Sample fetch address, held until done |
| bus_rdata | input | 8 | Data returned by the bus |
| cpu_halt | output | 1 | Stops the CPU |
| bus_addr | output | AW | Bus address this cycle |
| bus_rd | output | 1 | Bus direction, 1 = read |
| bus_wdata | output | 8 | Bus write data |
| spr_wr | output | 1 | Sprite byte write to the data port |
| smp_done | output | 1 | One-cycle pulse after a sample fetch |
| smp_data | output | 8 | Fetched sample byte |

## Verification
The bench builds the block with BYTES=4 instead of 256, so a whole sprite copy fits in about a dozen cycles. This short length puts the start of a copy, a stolen get slot, a second back-to-back sample fetch and the halt release after the last write all inside one short trace. The trace checks every cycle. Page 0x03 and page 0x05 copies begin on opposite grid parities, which exercises the alignment and no-alignment paths, and one sample request is made against a CPU write cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        SM_IDLE,
        SM_REQ,
        SM_DUMMY,
        SM_FETCH
    } smp_st_e;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_ARMED,
        SP_RUN
    } spr_st_e;
endpackage

// File: rtl/dma_smp_eng.sv
module dma_smp_eng
    import dma_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          halt_ok,
    input  logic          get_cyc,
    input  logic [DW-1:0] rdata,
    output logic          wait_halt,
    output logic          busy_next,
    output logic          fetch,
    output logic          done,
    output logic [DW-1:0] data
);
    typedef struct packed {
        smp_st_e       st;
        logic          done;
        logic [DW-1:0] data;
    } smp_state_t;

    smp_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        fetch    = 1'b0;
        case (s_q.st)
            SM_IDLE:  if (req) s_d.st = SM_REQ;
            SM_REQ:   if (halt_ok) s_d.st = SM_DUMMY;
            SM_DUMMY: s_d.st = SM_FETCH;
            SM_FETCH: begin
                if (get_cyc) begin
                    fetch     = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.data  = rdata;
                    s_d.st    = req ? SM_REQ : SM_IDLE;
                end
            end
            default:  s_d.st = SM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SM_IDLE, done: 1'b0, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wait_halt = (s_q.st == SM_REQ);
    assign busy_next = (s_d.st != SM_IDLE);
    assign done      = s_q.done;
    assign data      = s_q.data;

    // R6
    fetch_on_get_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |-> get_cyc);

    // R7
    done_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> done);
endmodule

// File: rtl/dma_spr_eng.sv
module dma_spr_eng
    import dma_seq_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter int          BYTES     = 256,
    parameter logic [15:0] PORT_ADDR = 16'h2004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic [AW-9:0] trig_page,
    input  logic          halt_ok,
    input  logic          get_cyc,
    input  logic          steal,
    input  logic [DW-1:0] rdata,
    output logic          wait_halt,
    output logic          busy_next,
    output logic          rd_now,
    output logic          wr_now,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata
);
    localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BYTES - 1);

    typedef struct packed {
        spr_st_e       st;
        logic [AW-9:0] page;
        logic [CW-1:0] cnt;
        logic          phase;
        logic [DW-1:0] buf_b;
    } spr_state_t;

    spr_state_t s_q, s_d;
    logic [7:0] lo_byte;

    always_comb begin
        s_d    = s_q;
        rd_now = 1'b0;
        wr_now = 1'b0;
        case (s_q.st)
            SP_IDLE: begin
                if (trig) begin
                    s_d.st    = SP_ARMED;
                    s_d.page  = trig_page;
                    s_d.cnt   = '0;
                    s_d.phase = 1'b0;
                end
            end
            SP_ARMED: if (halt_ok) s_d.st = SP_RUN;
            SP_RUN: begin
                if (!s_q.phase && get_cyc && !steal) begin
                    rd_now     = 1'b1;
                    s_d.buf_b  = rdata;
                    s_d.phase  = 1'b1;
                end else if (s_q.phase && !get_cyc) begin
                    wr_now    = 1'b1;
                    s_d.phase = 1'b0;
                    s_d.cnt   = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST) s_d.st = SP_IDLE;
                end
            end
            default: s_d.st = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SP_IDLE, page: '0, cnt: '0, phase: 1'b0, buf_b: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign lo_byte   = 8'(s_q.cnt);
    assign addr      = rd_now ? {s_q.page, lo_byte} : AW'(PORT_ADDR);
    assign wdata     = s_q.buf_b;
    assign wait_halt = (s_q.st == SP_ARMED);
    assign busy_next = (s_d.st != SP_IDLE);

    // R4
    spr_wr_on_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |-> !get_cyc);

    // R4
    spr_rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |-> $past(rd_now) || $past(s_q.phase));
endmodule

// File: rtl/sprdma_seq.sv
module sprdma_seq
    import dma_seq_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          BYTES     = 256,
    parameter logic [15:0] TRIG_ADDR = 16'h4014,
    parameter logic [15:0] PORT_ADDR = 16'h2004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          get_cyc,
    input  logic          cpu_rd,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          smp_req,
    input  logic [AW-1:0] smp_addr,
    input  logic [7:0]    bus_rdata,
    output logic          cpu_halt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic [7:0]    bus_wdata,
    output logic          spr_wr,
    output logic          smp_done,
    output logic [7:0]    smp_data
);
    localparam int DW = 8;

    typedef struct packed {
        logic halt;
    } top_state_t;

    top_state_t t_q, t_d;

    logic          halt_ok;
    logic          trig;
    logic          smp_wait, smp_busy_n, smp_fetch;
    logic          spr_wait, spr_busy_n, spr_rd;
    logic [AW-1:0] spr_addr;
    logic [DW-1:0] spr_wdata;

    assign halt_ok = t_q.halt | cpu_rd;
    assign trig    = !cpu_rd && !t_q.halt && (cpu_addr == AW'(TRIG_ADDR));

    dma_smp_eng #(.DW(DW)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (smp_req),
        .halt_ok   (halt_ok),
        .get_cyc   (get_cyc),
        .rdata     (bus_rdata),
        .wait_halt (smp_wait),
        .busy_next (smp_busy_n),
        .fetch     (smp_fetch),
        .done      (smp_done),
        .data      (smp_data)
    );

    dma_spr_eng #(
        .AW        (AW),
        .DW        (DW),
        .BYTES     (BYTES),
        .PORT_ADDR (PORT_ADDR)
    ) u_spr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_page (cpu_wdata[AW-9:0]),
        .halt_ok   (halt_ok),
        .get_cyc   (get_cyc),
        .steal     (smp_fetch),
        .rdata     (bus_rdata),
        .wait_halt (spr_wait),
        .busy_next (spr_busy_n),
        .rd_now    (spr_rd),
        .wr_now    (spr_wr),
        .addr      (spr_addr),
        .wdata     (spr_wdata)
    );

    always_comb begin
        cpu_halt  = t_q.halt | (cpu_rd & (smp_wait | spr_wait));
        t_d.halt  = cpu_halt & (smp_busy_n | spr_busy_n);
        bus_wdata = cpu_wdata;
        if (spr_wr) begin
            bus_addr  = spr_addr;
            bus_rd    = 1'b0;
            bus_wdata = spr_wdata;
        end else if (smp_fetch) begin
            bus_addr = smp_addr;
            bus_rd   = 1'b1;
        end else if (spr_rd) begin
            bus_addr = spr_addr;
            bus_rd   = 1'b1;
        end else if (cpu_halt) begin
            bus_addr = cpu_addr;
            bus_rd   = 1'b1;
        end else begin
            bus_addr = cpu_addr;
            bus_rd   = cpu_rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{halt: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    // R2
    halt_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> cpu_rd);

    // R8
    one_get_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_fetch && spr_rd));

    // R4
    dma_access_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_rd || spr_wr || smp_fetch) |-> cpu_halt);

    // R10
    idle_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !smp_done);
endmodule

// File: tb/sim_sprdma_seq.sv
module sim_sprdma_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        get_cyc, cpu_rd, smp_req;
    logic [15:0] cpu_addr, smp_addr, bus_addr;
    logic [7:0]  cpu_wdata, bus_rdata, bus_wdata, smp_data;
    logic        cpu_halt, bus_rd, spr_wr, smp_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    sprdma_seq #(.AW(16), .BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .get_cyc(get_cyc), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .smp_req(smp_req),
        .smp_addr(smp_addr), .bus_rdata(bus_rdata), .cpu_halt(cpu_halt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .spr_wr(spr_wr), .smp_done(smp_done), .smp_data(smp_data)
    );

    // fields: get rd addr wdata sreq | halt baddr brd swr bwdata done sdata
    localparam int NV = 33;
    localparam logic [62:0] VEC [NV] = '{
        {1'b1,1'b0,16'h4014,8'h03,1'b0, 1'b0,16'h4014,1'b0,1'b0,8'h03,1'b0,8'h00}, // 0 R1
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 1 R2
        {1'b1,1'b1,16'h8000,8'h00,1'b1, 1'b1,16'h0300,1'b1,1'b0,8'h00,1'b0,8'h00}, // 2 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA5,1'b0,8'h00}, // 3 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0301,1'b1,1'b0,8'h00,1'b0,8'h00}, // 4 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA4,1'b0,8'h00}, // 5 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b1, 1'b1,16'hC010,1'b1,1'b0,8'h00,1'b0,8'h00}, // 6 R8
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b1,8'hB5}, // 7 R7
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0302,1'b1,1'b0,8'h00,1'b0,8'h00}, // 8 R9
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA7,1'b0,8'h00}, // 9 R9
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'hC010,1'b1,1'b0,8'h00,1'b0,8'h00}, // 10 R8
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b1,8'hB5}, // 11 R7
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0303,1'b1,1'b0,8'h00,1'b0,8'h00}, // 12 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA6,1'b0,8'h00}, // 13 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b0,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 14 R5
        {1'b1,1'b1,16'h8000,8'h00,1'b1, 1'b0,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 15 R6
        {1'b0,1'b0,16'h0200,8'h77,1'b0, 1'b0,16'h0200,1'b0,1'b0,8'h77,1'b0,8'h00}, // 16 R2
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 17 R2
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 18 R6
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'hC010,1'b1,1'b0,8'h00,1'b0,8'h00}, // 19 R6
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b0,16'h8000,1'b1,1'b0,8'h00,1'b1,8'hB5}, // 20 R7
        {1'b0,1'b0,16'h4014,8'h05,1'b0, 1'b0,16'h4014,1'b0,1'b0,8'h05,1'b0,8'h00}, // 21 R1
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 22 R2
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}, // 23 R3
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0500,1'b1,1'b0,8'h00,1'b0,8'h00}, // 24 R3
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA5,1'b0,8'h00}, // 25 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0501,1'b1,1'b0,8'h00,1'b0,8'h00}, // 26 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA4,1'b0,8'h00}, // 27 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0502,1'b1,1'b0,8'h00,1'b0,8'h00}, // 28 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA7,1'b0,8'h00}, // 29 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h0503,1'b1,1'b0,8'h00,1'b0,8'h00}, // 30 R4
        {1'b0,1'b1,16'h8000,8'h00,1'b0, 1'b1,16'h2004,1'b0,1'b1,8'hA6,1'b0,8'h00}, // 31 R4
        {1'b1,1'b1,16'h8000,8'h00,1'b0, 1'b0,16'h8000,1'b1,1'b0,8'h00,1'b0,8'h00}  // 32 R5
    };

    function automatic string row_req(int r);
        case (r)
            0, 21:        return "R1";
            1, 16, 17, 22: return "R2";
            23, 24:       return "R3";
            6, 10:        return "R8";
            7, 11, 20:    return "R7";
            8, 9:         return "R9";
            14, 32:       return "R5";
            15, 18, 19:   return "R6";
            default:      return "R4";
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit g, input bit r, input logic [15:0] a,
                         input logic [7:0] w, input bit s);
        get_cyc = g; cpu_rd = r; cpu_addr = a; cpu_wdata = w; smp_req = s;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        smp_addr = 16'hC010;
        rst_n = 1'b0;
        drive(1'b0, 1'b1, 16'h8000, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check("R10", cpu_halt == 1'b0 && smp_done == 1'b0 && bus_addr == 16'h8000 && bus_rd,
              {cpu_halt, smp_done, bus_rd, bus_addr}, {3'b001, 16'h8000});
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [62:0] v;
            logic [35:0] act, exp;
            v = VEC[i];
            drive(v[62], v[61], v[60:45], v[44:37], v[36]);
            #1;
            exp = {v[35], v[34:19], v[18], v[17], v[16:9], v[8], v[8] ? v[7:0] : 8'h00};
            act = {cpu_halt, bus_addr, bus_rd, spr_wr, bus_wdata, smp_done,
                   smp_done ? smp_data : 8'h00};
            check(row_req(i), act === exp, {28'h0, act}, {28'h0, exp});
            @(negedge clk);
        end

        // R10: reset in the middle of a copy drops the halt and the copy
        drive(1'b1, 1'b0, 16'h4014, 8'h07, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b1, 16'h8000, 8'h00, 1'b0);
        @(negedge clk);
        drive(1'b1, 1'b1, 16'h8000, 8'h00, 1'b0);
        #1;
        check("R4", bus_addr == 16'h0700 && cpu_halt, {cpu_halt, bus_addr}, {1'b1, 16'h0700});
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R10", !cpu_halt && bus_addr == 16'h8000, {cpu_halt, bus_addr}, {1'b0, 16'h8000});
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            drive(k[0] ? 1'b1 : 1'b0, 1'b1, 16'h8000, 8'h00, 1'b0);
            #1;
            check("R10", !cpu_halt && !spr_wr && bus_addr == 16'h8000,
                  {cpu_halt, spr_wr, bus_addr}, {2'b00, 16'h8000});
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule